// File: doc/BRIEF.md
# Light and Proximity Threshold Interrupt Unit

This unit watches the finished results of an ambient-light channel and a proximity channel. Each result arrives with a one-clock valid strobe. The unit compares the result against a programmable low threshold and a programmable high threshold. A consecutive-count filter then decides whether the channel raises its interrupt flag. Flags stay set until the register file sends a write-zero clear strobe. An active-low interrupt pin is built from the flags of the enabled channels. The pin can hold its level, or it can give one clock-wide low strobe for each qualifying result.

In a second mode the pin stops carrying interrupts and shows proximity instead. A two-state machine, `PX_FAR` and `PX_NEAR`, applies hysteresis to the proximity results. It moves `PX_FAR -> PX_NEAR` after enough consecutive results at or above the high threshold. It moves `PX_NEAR -> PX_FAR` after enough consecutive results below the low threshold. Results between the two thresholds leave the state unchanged.

A second two-state machine drives the strobe: `PD_IDLE -> PD_STROBE` when an enabled channel fires, and `PD_STROBE -> PD_IDLE` on the next clock unless another enabled channel fires.

The proximity thresholds can be narrowed to 8-bit resolution. In that case their upper bits are ignored.

Top module: `prox_light_irq`

## Requirements
- R1: A result is out of range when it is greater than or equal to the high threshold, or strictly less than the low threshold. A result equal to the low threshold is in range.
- R2: With a persistence setting of 0, every completed result sets the channel's flag, whatever its value.
- R3: With a persistence setting of N (1 to 15), the flag is set only on the Nth consecutive out-of-range result. Any in-range result restarts the count. The count saturates at 15, so the channel keeps firing while excursions continue.
- R4: A set flag stays set until a clear strobe arrives for it. When a clear strobe and a firing result arrive in the same cycle, the flag stays set.
- R5: In level mode (`pulse_mode`=0, `prox_mode`=0), `irq_n` is 0 while any channel has both its flag and its enable at 1, and 1 otherwise. A channel whose enable is 0 never pulls the pin low.
- R6: In pulse mode (`pulse_mode`=1, `prox_mode`=0), `irq_n` is 0 for exactly the one clock that follows each result that fires an enabled channel. It is 1 afterwards without any clear strobe.
- R7: In proximity-output mode (`prox_mode`=1), `irq_n` equals the inverse of `near_flag`. `near_flag` goes to 1 on results at or above the high threshold and to 0 on results below the low threshold. Results between the thresholds hold it.
- R8: Both proximity transitions need `ps_persist` consecutive qualifying results, with 0 treated as 1. A non-qualifying result restarts the count.
- R9: With `ps_res8`=1, bits 9:8 of both proximity thresholds are treated as zero.
- R10: After reset, `irq_n`=1, both flags are 0 and `near_flag` is 0.
- R11: The flags, `near_flag` and `irq_n` change on the same clock edge that samples the valid strobe of the result that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| als_valid | input | 1 | Light result strobe |
| als_value | input | 16 | Light result |
| als_lo_thr | input | 16 | Light low threshold |
| als_hi_thr | input | 16 | Light high threshold |
| als_persist | input | 4 | Light consecutive-count setting |
| als_irq_en | input | 1 | Light interrupt enable |
| als_flag_clr | input | 1 | Light flag write-zero strobe |
| ps_valid | input | 1 | Proximity result strobe |
| ps_value | input | 10 | Proximity result |
| ps_lo_thr | input | 10 | Proximity low threshold |
| ps_hi_thr | input | 10 | Proximity high threshold |
| ps_res8 | input | 1 | 1 selects 8-bit proximity thresholds |
| ps_persist | input | 4 | Proximity consecutive-count setting |
| ps_irq_en | input | 1 | Proximity interrupt enable |
| ps_flag_clr | input | 1 | Proximity flag write-zero strobe |
| pulse_mode | input | 1 | 1 selects one-clock strobe output |
| prox_mode | input | 1 | 1 turns the pin into the near/far output |
| irq_n | output | 1 | Active-low interrupt pin; 1 means released |
| als_flag | output | 1 | Light interrupt flag |
| ps_flag | output | 1 | Proximity interrupt flag |
| near_flag | output | 1 | Proximity detect state, 1 = near |

## Verification
The assertions check these rules on every cycle:
- an in-range result empties a persistence count;
- the near/far state holds on between-threshold results;
- a flag only rises after a firing result, and it holds until it is cleared;
- a clear with no firing result empties the flag;
- a pulse-mode low always follows a firing, enabled channel.

Only the bench scenarios can show the following, by comparing the outputs with a behavioural model on every clock:
- the exact firing count for each persistence value;
- the equal-to-threshold boundaries;
- set winning over a clear in the same cycle;
- the narrowed proximity thresholds;
- the hysteresis sequence of the near/far output.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CH_ALS = 0;
    localparam int CH_PS  = 1;
    localparam int N_CH   = 2;

    typedef enum logic {
        PX_FAR  = 1'b0,
        PX_NEAR = 1'b1
    } prox_state_e;

    typedef enum logic {
        PD_IDLE   = 1'b0,
        PD_STROBE = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/range_judge.sv
module range_judge #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] lo_thr,
    input  logic [W-1:0] hi_thr,
    output logic         at_or_above_hi,
    output logic         below_lo
);
    always_comb begin
        at_or_above_hi = (value >= hi_thr);
        below_lo       = (value <  lo_thr);
    end
endmodule

// File: rtl/persist_filter.sv
module persist_filter #(
    parameter int PW            = 4,
    parameter bit ZERO_ANY      = 1'b1,
    parameter bit CLEAR_ON_FIRE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          hit,
    input  logic [PW-1:0] persist,
    output logic          fire
);
    localparam logic [PW-1:0] CNT_MAX = '1;
    localparam logic [PW-1:0] CNT_ONE = PW'(1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cnt_nx;

    always_comb begin
        if (!hit)
            cnt_nx = '0;
        else if (cnt_q == CNT_MAX)
            cnt_nx = CNT_MAX;
        else
            cnt_nx = cnt_q + CNT_ONE;

        fire = valid && ((ZERO_ANY && (persist == '0)) ||
                         (hit && (cnt_nx >= persist)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (valid) begin
            if (CLEAR_ON_FIRE && fire)
                cnt_q <= '0;
            else
                cnt_q <= cnt_nx;
        end
    end

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !hit) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/prox_tracker.sv
module prox_tracker #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          at_or_above_hi,
    input  logic          below_lo,
    input  logic [PW-1:0] persist,
    output logic          near
);
    import irq_pkg::*;

    prox_state_e state_q, state_d;
    logic        qual;
    logic        flip;

    always_comb begin
        unique case (state_q)
            PX_FAR:  qual = at_or_above_hi;
            PX_NEAR: qual = below_lo;
            default: qual = 1'b0;
        endcase
    end

    persist_filter #(
        .PW            (PW),
        .ZERO_ANY      (1'b0),
        .CLEAR_ON_FIRE (1'b1)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid),
        .hit     (qual),
        .persist (persist),
        .fire    (flip)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PX_FAR:  if (flip) state_d = PX_NEAR;
            PX_NEAR: if (flip) state_d = PX_FAR;
            default: state_d = PX_FAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PX_FAR;
        else
            state_q <= state_d;
    end

    always_comb near = (state_q == PX_NEAR);

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !at_or_above_hi && !below_lo) |=> $stable(state_q)); // R7

endmodule

// File: rtl/pin_driver.sv
module pin_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_req,
    input  logic level_req,
    input  logic near,
    input  logic pulse_mode,
    input  logic prox_mode,
    output logic irq_n
);
    import irq_pkg::*;

    pulse_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE:   if (pulse_req)  state_d = PD_STROBE;
            PD_STROBE: if (!pulse_req) state_d = PD_IDLE;
            default:   state_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PD_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        if (prox_mode)
            irq_n = !near;
        else if (pulse_mode)
            irq_n = (state_q != PD_STROBE);
        else
            irq_n = !level_req;
    end

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && !prox_mode && !irq_n) |-> $past(pulse_req)); // R6

endmodule

// File: rtl/prox_light_irq.sv
module prox_light_irq #(
    parameter int ALS_W = 16,
    parameter int PS_W  = 10,
    parameter int NAR_W = 8,
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             als_valid,
    input  logic [ALS_W-1:0] als_value,
    input  logic [ALS_W-1:0] als_lo_thr,
    input  logic [ALS_W-1:0] als_hi_thr,
    input  logic [PER_W-1:0] als_persist,
    input  logic             als_irq_en,
    input  logic             als_flag_clr,
    input  logic             ps_valid,
    input  logic [PS_W-1:0]  ps_value,
    input  logic [PS_W-1:0]  ps_lo_thr,
    input  logic [PS_W-1:0]  ps_hi_thr,
    input  logic             ps_res8,
    input  logic [PER_W-1:0] ps_persist,
    input  logic             ps_irq_en,
    input  logic             ps_flag_clr,
    input  logic             pulse_mode,
    input  logic             prox_mode,
    output logic             irq_n,
    output logic             als_flag,
    output logic             ps_flag,
    output logic             near_flag
);
    import irq_pkg::*;

    localparam int TOP_W = PS_W - NAR_W;

    logic [PS_W-1:0] ps_lo_eff, ps_hi_eff;
    logic als_hi_hit, als_lo_hit, ps_hi_hit, ps_lo_hit;
    logic [N_CH-1:0] trig, clr, en, flag_q;
    logic pulse_req, level_req;

    // narrowed resolution masks the upper threshold bits
    generate
        if (TOP_W > 0) begin : g_narrow
            always_comb begin
                ps_lo_eff = ps_res8 ? {{TOP_W{1'b0}}, ps_lo_thr[NAR_W-1:0]} : ps_lo_thr;
                ps_hi_eff = ps_res8 ? {{TOP_W{1'b0}}, ps_hi_thr[NAR_W-1:0]} : ps_hi_thr;
            end
        end else begin : g_wide
            logic unused_res8;
            always_comb begin
                ps_lo_eff   = ps_lo_thr;
                ps_hi_eff   = ps_hi_thr;
                unused_res8 = ps_res8;
            end
        end
    endgenerate

    range_judge #(.W(ALS_W)) u_als_judge (
        .value          (als_value),
        .lo_thr         (als_lo_thr),
        .hi_thr         (als_hi_thr),
        .at_or_above_hi (als_hi_hit),
        .below_lo       (als_lo_hit)
    );

    range_judge #(.W(PS_W)) u_ps_judge (
        .value          (ps_value),
        .lo_thr         (ps_lo_eff),
        .hi_thr         (ps_hi_eff),
        .at_or_above_hi (ps_hi_hit),
        .below_lo       (ps_lo_hit)
    );

    persist_filter #(.PW(PER_W), .ZERO_ANY(1'b1), .CLEAR_ON_FIRE(1'b0)) u_als_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (als_valid),
        .hit     (als_hi_hit || als_lo_hit),
        .persist (als_persist),
        .fire    (trig[CH_ALS])
    );

    persist_filter #(.PW(PER_W), .ZERO_ANY(1'b1), .CLEAR_ON_FIRE(1'b0)) u_ps_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (ps_valid),
        .hit     (ps_hi_hit || ps_lo_hit),
        .persist (ps_persist),
        .fire    (trig[CH_PS])
    );

    prox_tracker #(.PW(PER_W)) u_prox (
        .clk            (clk),
        .rst_n          (rst_n),
        .valid          (ps_valid),
        .at_or_above_hi (ps_hi_hit),
        .below_lo       (ps_lo_hit),
        .persist        (ps_persist),
        .near           (near_flag)
    );

    always_comb begin
        clr[CH_ALS] = als_flag_clr;
        clr[CH_PS]  = ps_flag_clr;
        en[CH_ALS]  = als_irq_en;
        en[CH_PS]   = ps_irq_en;
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q[c] <= 1'b0;
                else if (trig[c])
                    flag_q[c] <= 1'b1;
                else if (clr[c])
                    flag_q[c] <= 1'b0;
            end

            AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[c] && !clr[c]) |=> flag_q[c]); // R4
            AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[c] && !trig[c]) |=> !flag_q[c]); // R4
            AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[c]) |-> $past(trig[c])); // R2
        end
    endgenerate

    always_comb begin
        pulse_req = |(trig & en);
        level_req = |(flag_q & en);
        als_flag  = flag_q[CH_ALS];
        ps_flag   = flag_q[CH_PS];
    end

    pin_driver u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_req  (pulse_req),
        .level_req  (level_req),
        .near       (near_flag),
        .pulse_mode (pulse_mode),
        .prox_mode  (prox_mode),
        .irq_n      (irq_n)
    );

endmodule

// File: tb/prox_light_irq_tb.sv
`timescale 1ns/1ps
module prox_light_irq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic als_valid = 0, als_irq_en = 1, als_flag_clr = 0;
    logic [15:0] als_value = 0, als_lo_thr = 16'd100, als_hi_thr = 16'd1000;
    logic [3:0] als_persist = 0, ps_persist = 0;
    logic ps_valid = 0, ps_res8 = 0, ps_irq_en = 0, ps_flag_clr = 0;
    logic [9:0] ps_value = 0, ps_lo_thr = 10'd50, ps_hi_thr = 10'd200;
    logic pulse_mode = 0, prox_mode = 0;
    logic irq_n, als_flag, ps_flag, near_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R10";

    always #4 clk = ~clk;

    prox_light_irq u_dut (
        .clk(clk), .rst_n(rst_n),
        .als_valid(als_valid), .als_value(als_value),
        .als_lo_thr(als_lo_thr), .als_hi_thr(als_hi_thr),
        .als_persist(als_persist), .als_irq_en(als_irq_en), .als_flag_clr(als_flag_clr),
        .ps_valid(ps_valid), .ps_value(ps_value),
        .ps_lo_thr(ps_lo_thr), .ps_hi_thr(ps_hi_thr), .ps_res8(ps_res8),
        .ps_persist(ps_persist), .ps_irq_en(ps_irq_en), .ps_flag_clr(ps_flag_clr),
        .pulse_mode(pulse_mode), .prox_mode(prox_mode),
        .irq_n(irq_n), .als_flag(als_flag), .ps_flag(ps_flag), .near_flag(near_flag)
    );

    // behavioural reference model
    int m_acnt, m_pcnt, m_ncnt;
    bit m_aflag, m_pflag, m_near, m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acnt = 0; m_pcnt = 0; m_ncnt = 0;
            m_aflag = 0; m_pflag = 0; m_near = 0; m_pulse = 0;
        end else begin
            bit a_oor, p_oor, a_trig, p_trig, qual;
            int elo, ehi;
            a_oor = (als_value >= als_hi_thr) || (als_value < als_lo_thr);
            a_trig = 0;
            if (als_valid) begin
                m_acnt = a_oor ? ((m_acnt < 15) ? m_acnt + 1 : 15) : 0;
                a_trig = (als_persist == 0) || (a_oor && m_acnt >= int'(als_persist));
            end
            elo = ps_res8 ? int'(ps_lo_thr) % 256 : int'(ps_lo_thr);
            ehi = ps_res8 ? int'(ps_hi_thr) % 256 : int'(ps_hi_thr);
            p_oor = (int'(ps_value) >= ehi) || (int'(ps_value) < elo);
            p_trig = 0;
            if (ps_valid) begin
                m_pcnt = p_oor ? ((m_pcnt < 15) ? m_pcnt + 1 : 15) : 0;
                p_trig = (ps_persist == 0) || (p_oor && m_pcnt >= int'(ps_persist));
                qual = m_near ? (int'(ps_value) < elo) : (int'(ps_value) >= ehi);
                m_ncnt = qual ? ((m_ncnt < 15) ? m_ncnt + 1 : 15) : 0;
                if (qual && m_ncnt >= int'(ps_persist)) begin
                    m_near = !m_near;
                    m_ncnt = 0;
                end
            end
            if (a_trig) m_aflag = 1; else if (als_flag_clr) m_aflag = 0;
            if (p_trig) m_pflag = 1; else if (ps_flag_clr) m_pflag = 0;
            m_pulse = (a_trig && als_irq_en) || (p_trig && ps_irq_en);
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_pin();
        if (prox_mode) return !m_near;
        if (pulse_mode) return !m_pulse;
        return !((m_aflag && als_irq_en) || (m_pflag && ps_irq_en));
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk({cur_req, " irq_n"}, int'(irq_n), int'(exp_pin()));
            chk({cur_req, " als_flag"}, int'(als_flag), int'(m_aflag));
            chk({cur_req, " ps_flag"}, int'(ps_flag), int'(m_pflag));
            chk({cur_req, " near_flag"}, int'(near_flag), int'(m_near));
        end
    end

    task automatic put_als(int v);
        als_valid = 1; als_value = 16'(v);
        @(negedge clk);
        als_valid = 0;
    endtask

    task automatic put_ps(int v);
        ps_valid = 1; ps_value = 10'(v);
        @(negedge clk);
        ps_valid = 0;
    endtask

    task automatic clr_als();
        als_flag_clr = 1; @(negedge clk); als_flag_clr = 0;
    endtask

    task automatic clr_ps();
        ps_flag_clr = 1; @(negedge clk); ps_flag_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 irq_n", irq_n, 1); chk("R10 als_flag", als_flag, 0);
        chk("R10 ps_flag", ps_flag, 0); chk("R10 near_flag", near_flag, 0);
        @(negedge clk);

        // persistence 0: in-range result still fires
        cur_req = "R2";
        put_als(500); #1;
        chk("R2 flag on any result", als_flag, 1);
        chk("R11 pin at sampling edge", irq_n, 0);
        @(negedge clk);
        cur_req = "R4";
        clr_als(); #1;
        chk("R4 clear strobe", als_flag, 0); chk("R5 pin released", irq_n, 1);
        @(negedge clk);

        // persistence 3 with boundaries
        cur_req = "R3"; als_persist = 3;
        put_als(1000); #1; chk("R1 equal high is out", als_flag, 0); @(negedge clk);
        put_als(99);   #1; chk("R3 two in a row", als_flag, 0); @(negedge clk);
        put_als(500);  put_als(100); #1; chk("R1 equal low is in, restart", als_flag, 0); @(negedge clk);
        put_als(1000); put_als(2000); #1; chk("R3 restarted count", als_flag, 0); @(negedge clk);
        put_als(99);   #1; chk("R3 third consecutive fires", als_flag, 1); @(negedge clk);
        clr_als();
        put_als(2000); #1; chk("R3 saturated count fires", als_flag, 1); @(negedge clk);

        // enable gating
        cur_req = "R5";
        als_irq_en = 0; #1; chk("R5 disabled channel releases pin", irq_n, 1); @(negedge clk);
        als_irq_en = 1; #1; chk("R5 enabled channel pulls pin", irq_n, 0); @(negedge clk);

        // set wins over clear, flag holds
        cur_req = "R4";
        als_flag_clr = 1; put_als(3000); als_flag_clr = 0; #1;
        chk("R4 set beats clear", als_flag, 1);
        repeat (5) @(negedge clk); #1;
        chk("R4 flag holds", als_flag, 1); @(negedge clk);
        clr_als(); #1; chk("R4 cleared", als_flag, 0); @(negedge clk);

        // pulse mode
        cur_req = "R6"; pulse_mode = 1; als_persist = 0;
        put_als(500); #1; chk("R6 strobe low", irq_n, 0); @(negedge clk); #1;
        chk("R6 strobe one clock", irq_n, 1); @(negedge clk);
        put_als(7); put_als(8); #1; chk("R6 back-to-back stays low", irq_n, 0); @(negedge clk); #1;
        chk("R6 released", irq_n, 1); @(negedge clk);
        clr_als(); pulse_mode = 0;

        // narrowed proximity thresholds
        cur_req = "R9"; als_irq_en = 0; ps_irq_en = 1; ps_persist = 1;
        ps_res8 = 1; ps_lo_thr = 10'h004; ps_hi_thr = 10'h310;
        put_ps(10'h020); #1; chk("R9 8-bit high threshold", ps_flag, 1); @(negedge clk);
        clr_ps(); ps_res8 = 0;
        put_ps(10'h020); #1; chk("R9 10-bit in range", ps_flag, 0); @(negedge clk);

        // proximity output with hysteresis
        cur_req = "R7"; prox_mode = 1; ps_lo_thr = 10'd50; ps_hi_thr = 10'd200; ps_persist = 2;
        put_ps(10); put_ps(10); put_ps(10); #1;
        chk("R7 far state", near_flag, 0); chk("R7 pin released when far", irq_n, 1);
        @(negedge clk);
        put_ps(250); #1; chk("R8 one near result not enough", near_flag, 0); @(negedge clk);
        put_ps(200); #1; chk("R7 equal high goes near", near_flag, 1);
        chk("R7 pin low when near", irq_n, 0); @(negedge clk);
        put_ps(100); put_ps(50); #1; chk("R7 hold between", near_flag, 1); @(negedge clk);
        put_ps(40); put_ps(100); put_ps(40); #1; chk("R8 restart on non-qualifying", near_flag, 1); @(negedge clk);
        put_ps(40); #1; chk("R7 far after two below", near_flag, 0); chk("R7 pin released", irq_n, 1);
        @(negedge clk);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule